// File: doc/BRIEF.md
# Fine-Grained Multithreaded Issue Sequencer

This block is the front end of a barrel-style pipeline. It keeps a program counter for each of four hardware threads and chooses a thread afresh on every clock. The chosen thread's instruction word is read from a small internal ROM and placed in the first stage register, tagged with its thread number. That tag then moves through a short chain of stage registers, so every stage knows which thread it holds. A thread never issues in two consecutive slots, so an instruction never meets its direct predecessor from the same thread and no forwarding network is needed.

One thread is the real-time thread. It owns one slot in every `RT_PERIOD`, whatever the other threads are doing. When it is not ready, that slot goes to the others. The remaining slots rotate among the other ready threads. A stalled thread drops out of the rotation and its turns pass to the threads that can run. When nothing is eligible, the sequencer sends a bubble. A redirect input names a thread and a new PC. It reloads that thread's counter and cancels that thread's instructions already in the stage registers.

Top module: `fgmt_issue_seq`

## Requirements
- R1: After reset every stage valid bit is low. Thread t's program counter starts at t*THR_STRIDE, which is 0, 16, 32 and 48 with the defaults.
- R2: Per cycle at most one thread issues. A thread that holds the first stage register is not chosen for the next slot, so `issue_tid` never repeats on two consecutive valid issues.
- R3: Outside the reserved slot, the choice rotates over the ready, non-blocked threads other than the real-time thread. The search starts at the thread after the last one picked by rotation. That pointer resets to thread 0.
- R4: The real-time thread (thread 0 by default) is issued in each reserved slot in which it is ready, whatever the other threads do. The reserved slots are cycles 0, 4, 8 and so on, counted from the first clock edge after reset. It is never issued in any other slot.
- R5: When the real-time thread is not ready in its reserved slot, that slot is filled by rotation as in R3.
- R6: When no thread is eligible, the slot is a bubble: `issue_valid` and `stg_valid[0]` are low.
- R7: Each issue advances the issuing thread's PC by one. `issue_instr` equals {~pc, pc}, the bitwise inverse of the PC in the upper half and the PC in the lower half.
- R8: A redirect loads `redir_pc` into the named thread's PC, taking priority over the increment. That thread's next issue uses this PC. The other threads' PCs do not change.
- R9: A redirect clears the valid bit of every stage that holds the named thread. This includes an instruction of that thread chosen in the same cycle.
- R10: On every clock, stage k+1 takes the valid bit (masked per R9) and the thread tag of stage k. `stg_tid` packs stage k at bits [2k+1:2k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NUM_THR | Per-thread ready; low means stalled |
| redir_valid | input | 1 | Redirect request this cycle |
| redir_tid | input | TID_W | Thread being redirected |
| redir_pc | input | PC_W | New PC for that thread |
| issue_valid | output | 1 | First stage holds a live instruction |
| issue_tid | output | TID_W | Thread tag of the first stage |
| issue_pc | output | PC_W | PC of the issued instruction |
| issue_instr | output | 2*PC_W | ROM word at that PC |
| stg_valid | output | STAGES | Valid bit of each stage |
| stg_tid | output | STAGES*TID_W | Thread tag of each stage, packed |

## Verification
A redirect for a thread can arrive in the same cycle that the selector chooses that thread. Then the PC reload and the increment compete, and the fresh wrong-path issue has to be cancelled together with the older copies further down. The bench runs all threads ready and sends a redirect on every cycle for several cycles, cycling through the non-real-time threads. The rotation therefore lands on the redirected thread in some of those cycles. A cycle-stepped model, written from the requirements, predicts each stage's valid bit and tag and the next PC of every thread, and the bench compares against it. A second overlap, the reserved slot against a stalled real-time thread, is covered by a run with thread 0 held not ready.

// File: rtl/fgmt_pkg.sv
package fgmt_pkg;
  // Source of the thread chosen for the current slot
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_RT   = 2'd1,
    PICK_RR   = 2'd2
  } pick_e;
endpackage

// File: rtl/fgmt_thread_sel.sv
module fgmt_thread_sel
  import fgmt_pkg::*;
#(
  parameter int NUM_THR   = 4,
  parameter int TID_W     = 2,
  parameter int RT_THR    = 0,
  parameter int RT_PERIOD = 4,
  parameter int CNT_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] thr_ready,
  input  logic               last_valid,
  input  logic [TID_W-1:0]   last_tid,
  output logic               sel_valid,
  output logic [TID_W-1:0]   sel_tid
);

  logic [CNT_W-1:0]   slot_q, slot_d;
  logic [TID_W-1:0]   rr_q, rr_d, rr_tid;
  logic [NUM_THR-1:0] blocked, elig;
  logic               rt_slot;
  pick_e              pick;

  assign rt_slot = (slot_q == '0);

  always_comb begin
    blocked = '0;
    if (last_valid) blocked[last_tid] = 1'b1;
    elig = thr_ready & ~blocked;
    elig[RT_THR] = 1'b0;
    pick   = PICK_NONE;
    rr_tid = '0;
    for (int i = 1; i <= NUM_THR; i++) begin
      int idx;
      idx = (int'(rr_q) + i) % NUM_THR;
      if (pick == PICK_NONE && elig[TID_W'(idx)]) begin
        pick   = PICK_RR;
        rr_tid = TID_W'(idx);
      end
    end
    if (rt_slot && thr_ready[RT_THR] && !blocked[RT_THR]) pick = PICK_RT;
  end

  assign sel_valid = (pick != PICK_NONE);
  assign sel_tid   = (pick == PICK_RT) ? TID_W'(RT_THR) : rr_tid;

  always_comb begin
    slot_d = (slot_q == CNT_W'(RT_PERIOD - 1)) ? '0 : slot_q + 1'b1;
    rr_d   = (pick == PICK_RR) ? rr_tid : rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      rr_q   <= '0;
    end else begin
      slot_q <= slot_d;
      rr_q   <= rr_d;
    end
  end

  // R4: the reserved slot always goes to a ready real-time thread
  assert_rt_owns_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_slot && thr_ready[RT_THR]) |-> (sel_valid && sel_tid == TID_W'(RT_THR)));

  // R6: nothing ready means no issue
  assert_bubble_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready == '0) |-> !sel_valid);

endmodule

// File: rtl/fgmt_pc_bank.sv
module fgmt_pc_bank #(
  parameter int NUM_THR    = 4,
  parameter int TID_W      = 2,
  parameter int PC_W       = 8,
  parameter int THR_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_valid,
  input  logic [TID_W-1:0]  adv_tid,
  input  logic              redir_valid,
  input  logic [TID_W-1:0]  redir_tid,
  input  logic [PC_W-1:0]   redir_pc,
  output logic [PC_W-1:0]   rd_pc,
  output logic [2*PC_W-1:0] rd_instr
);

  logic [PC_W-1:0] pc_q [NUM_THR];
  logic [PC_W-1:0] pc_d [NUM_THR];

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    always_comb begin
      pc_d[g] = pc_q[g];
      if (adv_valid && adv_tid == TID_W'(g)) pc_d[g] = pc_q[g] + 1'b1;
      if (redir_valid && redir_tid == TID_W'(g)) pc_d[g] = redir_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q[g] <= PC_W'(g * THR_STRIDE);
      else        pc_q[g] <= pc_d[g];
    end
  end

  // Instruction ROM: word content is a fixed function of the address
  assign rd_pc    = pc_q[adv_tid];
  assign rd_instr = {~rd_pc, rd_pc};

  // R8: a redirect lands in the named thread's counter
  assert_redir_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (pc_q[$past(redir_tid)] == $past(redir_pc)));

endmodule

// File: rtl/fgmt_stage_pipe.sv
module fgmt_stage_pipe #(
  parameter int STAGES = 3,
  parameter int TID_W  = 2,
  parameter int PC_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [TID_W-1:0]        in_tid,
  input  logic [PC_W-1:0]         in_pc,
  input  logic [2*PC_W-1:0]       in_instr,
  input  logic                    kill_valid,
  input  logic [TID_W-1:0]        kill_tid,
  output logic [STAGES-1:0]       v_out,
  output logic [STAGES*TID_W-1:0] tid_out,
  output logic [PC_W-1:0]         pc0,
  output logic [2*PC_W-1:0]       instr0
);

  logic [STAGES-1:0] v_q, v_d;
  logic [TID_W-1:0]  tid_q [STAGES];
  logic [TID_W-1:0]  tid_d [STAGES];

  always_comb begin
    v_d[0]   = in_valid && !(kill_valid && kill_tid == in_tid);
    tid_d[0] = in_tid;
    for (int k = 1; k < STAGES; k++) begin
      v_d[k]   = v_q[k-1] && !(kill_valid && kill_tid == tid_q[k-1]);
      tid_d[k] = tid_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < STAGES; k++) tid_q[k] <= '0;
    end else begin
      v_q <= v_d;
      for (int k = 0; k < STAGES; k++) tid_q[k] <= tid_d[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc0    <= '0;
      instr0 <= '0;
    end else if (in_valid) begin
      pc0    <= in_pc;
      instr0 <= in_instr;
    end
  end

  assign v_out = v_q;
  for (genvar k = 0; k < STAGES; k++) begin : g_pack
    assign tid_out[k*TID_W +: TID_W] = tid_q[k];
  end

  // R9: a same-cycle pick of the redirected thread never becomes valid
  assert_squash_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_valid && in_valid && in_tid == kill_tid) |=> !v_q[0]);

  if (STAGES > 1) begin : g_chk
    // R9: an older copy of the redirected thread is dropped as it moves on
    assert_squash_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_valid && v_q[0] && tid_q[0] == kill_tid) |=> !v_q[1]);
    // R10: the tag travels with the instruction
    assert_tag_travels_R10: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[1] |-> ($past(v_q[0]) && tid_q[1] == $past(tid_q[0])));
  end

endmodule

// File: rtl/fgmt_issue_seq.sv
module fgmt_issue_seq #(
  parameter int NUM_THR    = 4,
  parameter int PC_W       = 8,
  parameter int STAGES     = 3,
  parameter int RT_THR     = 0,
  parameter int RT_PERIOD  = 4,
  parameter int THR_STRIDE = 16,
  localparam int TID_W     = $clog2(NUM_THR),
  localparam int INSTR_W   = 2 * PC_W,
  localparam int CNT_W     = (RT_PERIOD > 1) ? $clog2(RT_PERIOD) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_THR-1:0]      thr_ready,
  input  logic                    redir_valid,
  input  logic [TID_W-1:0]        redir_tid,
  input  logic [PC_W-1:0]         redir_pc,
  output logic                    issue_valid,
  output logic [TID_W-1:0]        issue_tid,
  output logic [PC_W-1:0]         issue_pc,
  output logic [INSTR_W-1:0]      issue_instr,
  output logic [STAGES-1:0]       stg_valid,
  output logic [STAGES*TID_W-1:0] stg_tid
);

  logic               sel_valid;
  logic [TID_W-1:0]   sel_tid;
  logic [PC_W-1:0]    rd_pc;
  logic [INSTR_W-1:0] rd_instr;

  fgmt_thread_sel #(
    .NUM_THR(NUM_THR), .TID_W(TID_W), .RT_THR(RT_THR),
    .RT_PERIOD(RT_PERIOD), .CNT_W(CNT_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready),
    .last_valid(stg_valid[0]), .last_tid(stg_tid[TID_W-1:0]),
    .sel_valid(sel_valid), .sel_tid(sel_tid)
  );

  fgmt_pc_bank #(
    .NUM_THR(NUM_THR), .TID_W(TID_W), .PC_W(PC_W), .THR_STRIDE(THR_STRIDE)
  ) u_pcs (
    .clk(clk), .rst_n(rst_n), .adv_valid(sel_valid), .adv_tid(sel_tid),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .rd_pc(rd_pc), .rd_instr(rd_instr)
  );

  fgmt_stage_pipe #(
    .STAGES(STAGES), .TID_W(TID_W), .PC_W(PC_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(sel_valid), .in_tid(sel_tid),
    .in_pc(rd_pc), .in_instr(rd_instr),
    .kill_valid(redir_valid), .kill_tid(redir_tid),
    .v_out(stg_valid), .tid_out(stg_tid), .pc0(issue_pc), .instr0(issue_instr)
  );

  assign issue_valid = stg_valid[0];
  assign issue_tid   = stg_tid[TID_W-1:0];

  // R2: no thread occupies two adjacent issue slots
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid)) |-> (issue_tid != $past(issue_tid)));

endmodule

// File: tb/fgmt_issue_seq_test.sv
`timescale 1ns/1ps
module fgmt_issue_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] thr_ready;
  logic       redir_valid;
  logic [1:0] redir_tid;
  logic [7:0] redir_pc;
  logic       issue_valid;
  logic [1:0] issue_tid;
  logic [7:0] issue_pc;
  logic [15:0] issue_instr;
  logic [2:0] stg_valid;
  logic [5:0] stg_tid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state, stepped once per clock
  int m_slot, m_rr, m_pc[4];
  bit m_v[3];
  int m_t[3];
  int m_pc0;

  always #2.5 clk = ~clk;

  fgmt_issue_seq uut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
    .issue_instr(issue_instr), .stg_valid(stg_valid), .stg_tid(stg_tid)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int k = 0; k < 3; k++) begin
      chk(tag, $sformatf("R10 stage%0d valid", k), int'(stg_valid[k]), int'(m_v[k]));
      if (m_v[k]) chk(tag, $sformatf("R10 stage%0d tid", k), int'(stg_tid[2*k +: 2]), m_t[k]);
    end
    if (m_v[0]) begin
      chk(tag, "R7 issue_pc", int'(issue_pc), m_pc0);
      chk(tag, "R7 issue_instr", int'(issue_instr), int'({~8'(m_pc0), 8'(m_pc0)}));
    end
  endtask

  task automatic cycle(input logic [3:0] rdy, input bit rv, input int rtid, input int rpc,
                       input string tag);
    bit sel_v, rr_pick;
    int sel;
    thr_ready   = rdy;
    redir_valid = rv;
    redir_tid   = 2'(rtid);
    redir_pc    = 8'(rpc);
    sel_v = 0; rr_pick = 0; sel = 0;
    for (int i = 1; i <= 4; i++) begin
      int c;
      c = (m_rr + i) % 4;
      if (!sel_v && c != 0 && rdy[c] && !(m_v[0] && m_t[0] == c)) begin
        sel_v = 1; rr_pick = 1; sel = c;
      end
    end
    if (m_slot == 0 && rdy[0] && !(m_v[0] && m_t[0] == 0)) begin
      sel_v = 1; rr_pick = 0; sel = 0;
    end
    for (int k = 2; k >= 1; k--) begin
      m_v[k] = m_v[k-1] && !(rv && m_t[k-1] == rtid);
      m_t[k] = m_t[k-1];
    end
    m_v[0] = sel_v && !(rv && sel == rtid);
    m_t[0] = sel;
    if (sel_v) begin
      m_pc0 = m_pc[sel];
      m_pc[sel] = (m_pc[sel] + 1) % 256;
    end
    if (rv) m_pc[rtid] = rpc % 256;
    if (rr_pick) m_rr = sel;
    m_slot = (m_slot + 1) % 4;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; thr_ready = '0; redir_valid = 0; redir_tid = '0; redir_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "stg_valid after reset", int'(stg_valid), 0);
    rst_n = 1'b1;
    m_slot = 0; m_rr = 0; m_pc0 = 0;
    for (int t = 0; t < 4; t++) m_pc[t] = 16 * t;
    for (int k = 0; k < 3; k++) begin m_v[k] = 0; m_t[k] = 0; end
    // the first issue of each thread exposes its reset PC
    cycle(4'b1111, 0, 0, 0, "R1");
    chk("R1", "thread0 start pc", int'(issue_pc), 0);
    cycle(4'b1111, 0, 0, 0, "R1");
    chk("R1", "thread1 start pc", int'(issue_pc), 16);
  endtask

  task automatic t_rotation;
    int prev;
    prev = -1;
    for (int i = 0; i < 12; i++) begin
      cycle(4'b1111, 0, 0, 0, "R3");
      if (issue_valid && prev >= 0) chk("R2", "no repeat", int'(issue_tid == 2'(prev)), 0);
      prev = issue_valid ? int'(issue_tid) : -1;
    end
  endtask

  task automatic t_rt_interval;
    // thread 0 must appear exactly on reserved slots, others busy
    for (int i = 0; i < 16; i++) begin
      bit reserved;
      reserved = (m_slot == 0);
      cycle(4'b1111, 0, 0, 0, "R4");
      chk("R4", "rt issue on reserved slot only",
          int'(issue_valid && issue_tid == 2'd0), int'(reserved));
    end
  endtask

  task automatic t_rt_stalled;
    for (int i = 0; i < 8; i++) begin
      cycle(4'b1110, 0, 0, 0, "R5");
      chk("R5", "slot filled without rt", int'(issue_valid && issue_tid != 2'd0), 1);
    end
  endtask

  task automatic t_single;
    for (int i = 0; i < 6; i++) cycle(4'b0100, 0, 0, 0, "R2");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 4; i++) begin
      cycle(4'b0000, 0, 0, 0, "R6");
      chk("R6", "bubble", int'(issue_valid), 0);
    end
  endtask

  task automatic t_redirect;
    // a redirect every cycle forces collisions with the selected thread
    for (int i = 0; i < 9; i++) cycle(4'b1111, 1, (i % 3) + 1, 8'h40 + 8 * i, "R9");
    for (int i = 0; i < 8; i++) cycle(4'b1111, 0, 0, 0, "R8");
    cycle(4'b1111, 1, 2, 8'hC0, "R8");
    for (int i = 0; i < 6; i++) cycle(4'b1111, 0, 0, 0, "R8");
  endtask

  initial begin
    t_reset;
    t_rotation;
    t_rt_interval;
    t_rt_stalled;
    t_single;
    t_idle;
    t_redirect;
    t_rotation;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule